// File: doc/BRIEF.md
# Serial Socket Power Switch Controller

This block drives an external card-socket power switch over a three-wire serial link: a serial clock, a data line and a commit strobe. It watches the supply settings requested for two card sockets (a supply-voltage code and a programming-voltage code for each). When the request differs from the last value sent, it shifts out a fixed 11-bit control word and then pulses the strobe so that the switch applies the word.

The serial clock comes from a fixed integer division of the system bus clock. The default ratio is 36, which turns a 33 MHz bus clock into a serial clock of about 0.92 MHz. The switch's 2 MHz ceiling therefore holds for any bus clock up to 72 MHz. Data moves only while the serial clock is low, so the switch can capture each bit on the rising edge. A busy flag tells the host that a transfer is running. If the request changes during a transfer, the running word completes unchanged and the newest request is sent next. After reset the block first sends a word that switches both sockets off.

Top module: `sock_pwr_serializer`

## Requirements
- R1: After reset is released, the first word sent is all zeros (both sockets off), whatever the request inputs hold; if the request is non-zero, a second word carrying it follows.
- R2: The serial clock period is DIV bus-clock cycles (default 36), with exactly DIV/2 cycles high; consecutive rising edges within a word are DIV cycles apart.
- R3: A word is 11 bits sent MSB first: bits 10:9 socket A supply code, bits 8:7 socket A programming code, bits 6:5 socket B supply code, bits 4:3 socket B programming code, and bits 2:0 always zero. Supply code 00 = off, 01 = 5 V, 10 = 3.3 V.
- R4: The data line never changes while the serial clock is high; it changes only in a cycle where the clock is low.
- R5: The strobe rises at the falling clock edge DIV/2 cycles after the last rising edge and stays high for exactly DIV cycles, with the serial clock held low throughout.
- R6: Busy is high from the first cycle of the shift until the cycle in which the strobe is released, and both fall on the same bus-clock edge.
- R7: A request change during a transfer does not alter the word being sent; after that word ends, a new transfer carries the latest request, and intermediate values are never sent.
- R8: While the request equals the last value sent, no transfer starts: busy, the strobe and the serial clock all stay low.
- R9: When idle and during reset, the serial clock, data and strobe outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a_vcc | input | 2 | Socket A requested supply code |
| a_vpp | input | 2 | Socket A requested programming-voltage code |
| b_vcc | input | 2 | Socket B requested supply code |
| b_vpp | input | 2 | Socket B requested programming-voltage code |
| busy | output | 1 | High while a word is shifting or the strobe is high |
| sw_clk | output | 1 | Serial clock to the power switch |
| sw_data | output | 1 | Serial data to the power switch |
| sw_latch | output | 1 | Commit strobe to the power switch |

## Verification
The bench decodes words from the pins at each serial rising edge and compares them with the expected words for several request patterns. These cover the all-off reset word, two patterns with different codes in every field so that a swapped or shifted field shows up, and a reset with a non-zero request, which separates the forced off word from the requested one. A request that changes twice during a transfer tells the "finish then send latest" rule apart from a restart or from queuing every value. A long idle spell with a steady request shows whether words are resent. Every captured word also has its clock intervals, strobe placement and width, and busy release measured.

// File: rtl/spw_pkg.sv
// Package: shared types for the serial socket power switch controller.
// Assumes two sockets, each with a 2-bit supply code and a 2-bit programming code.
package spw_pkg;

    localparam int CODE_W = 2;

    // Requested settings; the packed order is the shift order (socket A supply first).
    typedef struct packed {
        logic [CODE_W-1:0] a_vcc;
        logic [CODE_W-1:0] a_vpp;
        logic [CODE_W-1:0] b_vcc;
        logic [CODE_W-1:0] b_vpp;
    } pwr_req_t;

    localparam int REQ_W = $bits(pwr_req_t);

    // Shifter states.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_LATCH = 2'd2
    } sh_state_t;

endpackage

// File: rtl/spw_req_track.sv
// Module: spw_req_track
// Decides when a new word must be sent. It remembers the last request that was
// sent and raises start while the shifter is idle and the request differs. After
// reset it forces one all-off word first.
// Assumes: start is consumed on the same edge by the shifter whenever idle is high.
module spw_req_track
    import spw_pkg::*;
#(
    parameter int RSV_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  pwr_req_t              req,
    input  logic                  idle,
    output logic                  start,
    output logic [REQ_W+RSV_W-1:0] start_word
);
    localparam int WORD_W = REQ_W + RSV_W;

    pwr_req_t sent_q;
    logic     init_q;
    pwr_req_t next_req;

    // Choose the value to send next: all-off after reset, else the live request.
    always_comb begin
        next_req   = init_q ? pwr_req_t'('0) : req;
        start      = idle && (init_q || (req != sent_q));
        start_word = {next_req, {RSV_W{1'b0}}};
    end

    // Record what was handed to the shifter and clear the post-reset flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sent_q <= '0;
            init_q <= 1'b1;
        end else if (start) begin
            sent_q <= next_req;
            init_q <= 1'b0;
        end
    end

    // R3: reserved bits handed to the shifter are always zero.
    a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (start_word[RSV_W-1:0] == '0));

    // R1: the first word after reset is all-off.
    a_r1_first_word_off: assert property (@(posedge clk) disable iff (!rst_n)
        (start && init_q) |-> (start_word == WORD_W'(0)));

endmodule

// File: rtl/spw_clk_gen.sv
// Module: spw_clk_gen
// Divides the bus clock for the serial link. While run is high a counter spans
// DIV cycles and marks the cycle before the rising and the falling serial edge.
// Held at zero while run is low, so each transfer starts with a fresh phase.
// Assumes DIV is even and at least 4.
module spw_clk_gen #(
    parameter int DIV = 36
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int HALF  = DIV / 2;
    localparam int CNT_W = $clog2(DIV);

    logic [CNT_W-1:0] cnt_q;

    // Mark the cycles that precede serial clock edges.
    always_comb begin
        rise_tick = run && (cnt_q == CNT_W'(HALF - 1));
        fall_tick = run && (cnt_q == CNT_W'(DIV - 1));
    end

    // Phase counter, wrapping every DIV cycles while running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == CNT_W'(DIV - 1)) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R2: the two edge marks never coincide.
    a_r2_ticks_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_tick && fall_tick));

endmodule

// File: rtl/spw_shifter.sv
// Module: spw_shifter
// Shifts one control word MSB first, then holds the commit strobe for one serial
// period. The serial clock rises and falls on ticks from spw_clk_gen; data
// advances only on falling edges.
// Assumes start is only asserted while idle is high.
module spw_shifter
    import spw_pkg::*;
#(
    parameter int WORD_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] start_word,
    input  logic              rise_tick,
    input  logic              fall_tick,
    output logic              idle,
    output logic              busy,
    output logic              sclk,
    output logic              sdata,
    output logic              slatch
);
    localparam int BIT_W = $clog2(WORD_W);

    sh_state_t         state_q;
    logic [WORD_W-1:0] shreg_q;
    logic [BIT_W-1:0]  bitcnt_q;
    logic              sclk_q;

    // Output decode from registered state.
    always_comb begin
        idle   = (state_q == ST_IDLE);
        busy   = !idle;
        sclk   = sclk_q;
        sdata  = (state_q == ST_SHIFT) ? shreg_q[WORD_W-1] : 1'b0;
        slatch = (state_q == ST_LATCH);
    end

    // Transfer sequencer: load, shift on falling edges, strobe, return to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            shreg_q  <= '0;
            bitcnt_q <= '0;
            sclk_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    sclk_q <= 1'b0;
                    if (start) begin
                        state_q  <= ST_SHIFT;
                        shreg_q  <= start_word;
                        bitcnt_q <= '0;
                    end
                end
                ST_SHIFT: begin
                    if (rise_tick) begin
                        sclk_q <= 1'b1;
                    end
                    if (fall_tick) begin
                        sclk_q <= 1'b0;
                        if (bitcnt_q == BIT_W'(WORD_W - 1)) begin
                            state_q <= ST_LATCH;
                        end else begin
                            shreg_q  <= {shreg_q[WORD_W-2:0], 1'b0};
                            bitcnt_q <= bitcnt_q + 1'b1;
                        end
                    end
                end
                ST_LATCH: begin
                    sclk_q <= 1'b0;
                    if (fall_tick) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                    sclk_q  <= 1'b0;
                end
            endcase
        end
    end

    // R4: data holds steady while the serial clock stays high.
    a_r4_data_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(sdata));

    // R5: the serial clock stays low while the strobe is high.
    a_r5_latch_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
        slatch |-> !sclk);

    // R6: busy covers the strobe and the release happens together.
    a_r6_busy_covers_latch: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(slatch) |-> !busy);

    // R9: idle means a quiet link.
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!sclk && !sdata && !slatch));

    // R2: a rising serial edge is followed by at least one more high cycle.
    a_r2_high_min: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |=> sclk);

endmodule

// File: rtl/sock_pwr_serializer.sv
// Module: sock_pwr_serializer (top)
// Sends two-socket power requests to an external switch over a clock/data/strobe
// link. Tracks request changes, divides the bus clock and shifts the word.
// Assumes the request inputs are synchronous to clk.
module sock_pwr_serializer
    import spw_pkg::*;
#(
    parameter int DIV   = 36,
    parameter int RSV_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] a_vcc,
    input  logic [CODE_W-1:0] a_vpp,
    input  logic [CODE_W-1:0] b_vcc,
    input  logic [CODE_W-1:0] b_vpp,
    output logic              busy,
    output logic              sw_clk,
    output logic              sw_data,
    output logic              sw_latch
);
    localparam int WORD_W = REQ_W + RSV_W;

    pwr_req_t          req;
    logic              start;
    logic [WORD_W-1:0] start_word;
    logic              idle;
    logic              rise_tick;
    logic              fall_tick;

    // Gather the request fields in shift order.
    always_comb begin
        req = '{a_vcc: a_vcc, a_vpp: a_vpp, b_vcc: b_vcc, b_vpp: b_vpp};
    end

    spw_req_track #(.RSV_W(RSV_W)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .idle       (idle),
        .start      (start),
        .start_word (start_word)
    );

    spw_clk_gen #(.DIV(DIV)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    spw_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_word (start_word),
        .rise_tick  (rise_tick),
        .fall_tick  (fall_tick),
        .idle       (idle),
        .busy       (busy),
        .sclk       (sw_clk),
        .sdata      (sw_data),
        .slatch     (sw_latch)
    );

endmodule

// File: tb/sock_pwr_serializer_tb.sv
module sock_pwr_serializer_tb;
    localparam int DIV  = 36;
    localparam int HALF = DIV / 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] a_vcc = 2'b00, a_vpp = 2'b00, b_vcc = 2'b00, b_vpp = 2'b00;
    logic busy, sw_clk, sw_data, sw_latch;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int data_viol = 0;
    logic pclk = 1'b0, pdata = 1'b0;

    always #4 clk = ~clk;

    sock_pwr_serializer #(.DIV(DIV)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .a_vcc(a_vcc), .a_vpp(a_vpp), .b_vcc(b_vcc), .b_vpp(b_vpp),
        .busy(busy), .sw_clk(sw_clk), .sw_data(sw_data), .sw_latch(sw_latch)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // R4 monitor: data may not move while the clock is high in both samples.
    always @(negedge clk) begin
        if (rst_n && sw_clk && pclk && (sw_data != pdata)) data_viol++;
        pclk  = sw_clk;
        pdata = sw_data;
    end

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    function automatic logic [10:0] mk(input logic [1:0] av, ap, bv, bp);
        return {av, ap, bv, bp, 3'b000};
    endfunction

    // Capture one word from the pins and measure its timing.
    task automatic recv_word(output logic [10:0] w, output int per_err, output int lat_err);
        int rises = 0, last_rise = -1, lat_start = -1, t = 0;
        logic ps = 1'b0, pl = 1'b0;
        bit done = 0;
        w = '0; per_err = 0; lat_err = 0;
        while (!busy && t < 3000) begin @(negedge clk); t++; end
        if (!busy) begin per_err = 99; return; end
        while (!done && t < 6000) begin
            @(negedge clk); t++;
            if (sw_clk && !ps) begin
                if (rises > 0 && (cyc - last_rise) != DIV) per_err++;
                last_rise = cyc; w = {w[9:0], sw_data}; rises++;
            end
            if (!sw_clk && ps && (cyc - last_rise) != HALF) per_err++;
            if (sw_latch && !pl) begin
                lat_start = cyc;
                if (rises != 11 || (cyc - last_rise) != HALF) lat_err++;
            end
            if (sw_latch && sw_clk) lat_err++;
            if (!sw_latch && pl) begin
                if ((cyc - lat_start) != DIV) lat_err++;
                if (busy) lat_err++;
                done = 1;
            end
            if (!busy && !done) lat_err++;
            ps = sw_clk; pl = sw_latch;
        end
        if (!done) lat_err += 50;
    endtask

    task automatic set_req(input logic [1:0] av, ap, bv, bp);
        a_vcc = av; a_vpp = ap; b_vcc = bv; b_vpp = bp;
    endtask

    task automatic expect_word(input logic [10:0] exp, input string rq);
        logic [10:0] w; int pe, le;
        recv_word(w, pe, le);
        check(w == exp, rq, int'(w), int'(exp));
        check(pe == 0, "R2 clock timing", pe, 0);
        check(le == 0, "R5/R6 strobe and busy timing", le, 0);
    endtask

    task automatic t_reset();
        set_req(2'b00, 2'b00, 2'b00, 2'b00);
        rst_n = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(!sw_clk && !sw_data && !sw_latch, "R9 quiet in reset",
              {sw_clk, sw_data, sw_latch}, 0);
        check(!busy, "R9 busy low in reset", busy, 0);
        rst_n = 1'b1;
        expect_word(11'd0, "R1 first word all-off");
    endtask

    task automatic t_patterns();
        // 5 V on A, 3.3 V on B, distinct programming codes.
        @(negedge clk); set_req(2'b01, 2'b11, 2'b10, 2'b01);
        expect_word(mk(2'b01, 2'b11, 2'b10, 2'b01), "R3 pattern one");
        @(negedge clk); set_req(2'b10, 2'b01, 2'b01, 2'b10);
        expect_word(mk(2'b10, 2'b01, 2'b01, 2'b10), "R3 pattern two");
    endtask

    task automatic t_no_change();
        int seen = 0;
        repeat (600) begin
            @(negedge clk);
            if (busy || sw_clk || sw_latch || sw_data) seen++;
        end
        check(seen == 0, "R8 no resend on steady request", seen, 0);
    endtask

    task automatic t_mid_change();
        logic [10:0] w1, w2; int pe, le;
        fork
            begin
                recv_word(w1, pe, le);
                check(w1 == mk(2'b01, 2'b00, 2'b00, 2'b00), "R7 running word kept",
                      int'(w1), int'(mk(2'b01, 2'b00, 2'b00, 2'b00)));
                recv_word(w2, pe, le);
                check(w2 == mk(2'b10, 2'b10, 2'b10, 2'b11), "R7 latest value sent",
                      int'(w2), int'(mk(2'b10, 2'b10, 2'b10, 2'b11)));
                check(pe == 0 && le == 0, "R7 second word timing", pe + le, 0);
            end
            begin
                @(negedge clk); set_req(2'b01, 2'b00, 2'b00, 2'b00);
                repeat (100) @(negedge clk);
                set_req(2'b11, 2'b01, 2'b01, 2'b01);
                repeat (100) @(negedge clk);
                set_req(2'b10, 2'b10, 2'b10, 2'b11);
            end
        join
        t_no_change();
    endtask

    task automatic t_reset_nonzero();
        @(negedge clk);
        rst_n = 1'b0;
        set_req(2'b10, 2'b00, 2'b01, 2'b00);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        expect_word(11'd0, "R1 off word before non-zero request");
        expect_word(mk(2'b10, 2'b00, 2'b01, 2'b00), "R1 request follows off word");
    endtask

    initial begin
        t_reset();
        t_patterns();
        t_no_change();
        t_mid_change();
        t_reset_nonzero();
        check(data_viol == 0, "R4 data steady while clock high", data_viol, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule